// File: doc/BRIEF.md
# Dual-Compare Timer/Counter

This block is a 16-bit up-counter that software drives through four word-wide registers on a simple register bus. The registers hold control, the live count and two compare values. Each count step comes from one of three places, chosen in control: the system clock, rising edges of an external pin, or a tick strobe from a separate prescaler timer. When a step would carry the count onto the active compare value, the count returns to zero instead. This is a maximum-count event. A compare value of zero therefore gives a full period of 65536 steps.

In single mode only compare A is used. The output drops low for one clock after each event, which gives a periodic strobe. In dual mode the two compare registers take turns. The output is high while A is active and low while B is active, so A and B set the high time and the low time of a square wave, and with them its frequency and duty cycle. A continuous timer keeps running after an event. A one-shot timer clears its own run bit when its pass ends. With interrupts enabled, every event raises a one-clock interrupt request. A parameter removes compare B to give the reduced variant, which can only serve as a prescaler or a periodic interrupt source.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every register reads 0, `tmr_out` is 1 and `irq` is 0. The address map is 0 control, 1 count, 2 compare A, 3 compare B.
- R2: With the clock source selected (control bits [5:4] = 0 or 3) and run (control bit 0) set, the count rises by one on every clock. While run is clear, the count holds.
- R3: A step that would make the count equal the active compare value loads 0 into the count and is a maximum-count event. A compare value of 0 makes the count wrap from 65535 to 0.
- R4: With interrupt enable (control bit 6) set, `irq` is high for exactly the one clock after each event. With it clear, `irq` stays 0.
- R5: In dual mode (control bit 3 set), each event swaps the active compare register. Status bit 7 of a control read is 1 while B is active. `tmr_out` is high while A is active and low while B is active.
- R6: In single mode, `tmr_out` is low for exactly the one clock after each event and high at all other times.
- R7: In one-shot single mode (control bit 2 clear), run clears at the event and the count then stays at 0.
- R8: In one-shot dual mode, run stays set at the end of the A pass and clears at the end of the B pass.
- R9: With the external source selected (bits [5:4] = 1), the count rises by one for each rising edge of `ext_in`, however long the pin stays high.
- R10: With the prescaler source selected (bits [5:4] = 2), the count rises by one on each clock in which `pre_tick` is high.
- R11: A control write updates run only when bit 1 of the written word is set. The other control fields always update.
- R12: A bus write to the count takes priority over a step in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ext_in | input | 1 | Asynchronous external count input |
| pre_tick | input | 1 | Prescaler tick strobe, synchronous |
| tmr_out | output | 1 | Timer waveform output |
| irq | output | 1 | Interrupt request pulse |

## Verification
A bus write lands at the rising edge on which the strobe is sampled. Every count step, event, `irq` pulse and `tmr_out` change shows at the outputs one clock after the edge that causes it. An external edge is first delayed by a two-stage synchronizer and an edge register, so it reaches the count within three clocks. The bench drives inputs on falling edges and reads on falling edges. It counts the exact number of rising edges from each stimulus to the cycle in which a result is due, and reads there. For the asynchronous input, it holds each level for four clocks before it reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_PRE  = 2'd2,
        SRC_CLK2 = 2'd3
    } src_e;

    typedef struct packed {
        logic ie;
        src_e src;
        logic dual;
        logic cont;
        logic run;
    } ctrl_t;

    localparam int BIT_RUN  = 0;
    localparam int BIT_WE   = 1;
    localparam int BIT_CONT = 2;
    localparam int BIT_DUAL = 3;
    localparam int BIT_SRC  = 4;
    localparam int BIT_IE   = 6;
    localparam int BIT_SELB = 7;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CMPA = 2'd2;
    localparam logic [1:0] A_CMPB = 2'd3;

    function automatic ctrl_t ctrl_apply(input logic [7:0] w, input ctrl_t old);
        ctrl_t n;
        n.ie   = w[BIT_IE];
        n.src  = src_e'(w[BIT_SRC+1:BIT_SRC]);
        n.dual = w[BIT_DUAL];
        n.cont = w[BIT_CONT];
        n.run  = w[BIT_WE] ? w[BIT_RUN] : old.run;
        return n;
    endfunction

    function automatic logic [7:0] ctrl_read(input ctrl_t c, input logic sel_b);
        return {sel_b, c.ie, c.src, c.dual, c.cont, 1'b0, c.run};
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic ext_in,
    input  logic pre_tick,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev;
    logic                   ext_rise;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= 1'b0;
        else     ext_prev <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev;

    always_comb begin
        unique case (src)
            SRC_EXT: tick = ext_rise;
            SRC_PRE: tick = pre_tick;
            default: tick = 1'b1;
        endcase
    end

    // R9: an edge detector can never step on two clocks in a row
    a_r9_one_step_per_edge: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_EXT && tick) |=> !(src == SRC_EXT && tick));
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
    parameter int W     = 16,
    parameter bit HAS_B = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic [W-1:0] wdata,
    input  logic         sel_b,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output logic [W-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst)       cmp_a <= '0;
        else if (wr_a) cmp_a <= wdata;
    end

    generate
        if (HAS_B) begin : g_b
            always_ff @(posedge clk) begin
                if (rst)       cmp_b <= '0;
                else if (wr_b) cmp_b <= wdata;
            end
            assign active = sel_b ? cmp_b : cmp_a;
        end else begin : g_no_b
            assign cmp_b  = '0;
            assign active = cmp_a;
        end
    endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] max_val,
    input  logic         dual_en,
    input  logic         cont,
    output logic [W-1:0] count,
    output logic         sel_b,
    output logic         evt,
    output logic         stop_req
);
    logic [W-1:0] nxt;
    logic         step;

    assign nxt      = count + W'(1);
    assign step     = run & tick & ~load;
    assign evt      = step & (nxt == max_val);
    assign stop_req = evt & ~cont & (~dual_en | sel_b);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= evt ? '0 : nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)                 sel_b <= 1'b0;
        else if (evt && dual_en) sel_b <= ~sel_b;
    end

    // R2: no step and no load leaves the count alone
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !(run && tick)) |=> $stable(count));
    // R12: a bus load wins over a step
    a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
    // R5: the active register only swaps in dual mode
    a_r5_sel_static: assert property (@(posedge clk) disable iff (rst)
        !dual_en |=> $stable(sel_b));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
#(
    parameter int W           = 16,
    parameter bit HAS_B       = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         ext_in,
    input  logic         pre_tick,
    output logic         tmr_out,
    output logic         irq
);
    localparam int PAD = W - 8;

    ctrl_t        ctrl_q;
    logic         tick;
    logic [W-1:0] cmp_a, cmp_b, active, count;
    logic         sel_b, evt, stop_req, dual_en, pulse_lo;
    logic         wr_ctrl, wr_cnt, wr_a, wr_b;

    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign wr_cnt  = bus_wr && bus_addr == A_CNT;
    assign wr_a    = bus_wr && bus_addr == A_CMPA;
    assign wr_b    = bus_wr && bus_addr == A_CMPB;
    assign dual_en = ctrl_q.dual & HAS_B;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_apply(bus_wdata[7:0], ctrl_q);
        end else if (stop_req) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            pulse_lo <= 1'b0;
        end else begin
            irq      <= evt & ctrl_q.ie;
            pulse_lo <= evt & ~dual_en;
        end
    end

    assign tmr_out = ~pulse_lo & ~sel_b;

    tmr_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst(rst), .src(ctrl_q.src),
        .ext_in(ext_in), .pre_tick(pre_tick), .tick(tick)
    );

    tmr_cmp_bank #(.W(W), .HAS_B(HAS_B)) u_cmp (
        .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b), .wdata(bus_wdata),
        .sel_b(sel_b), .cmp_a(cmp_a), .cmp_b(cmp_b), .active(active)
    );

    tmr_count_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick),
        .load(wr_cnt), .load_val(bus_wdata), .max_val(active),
        .dual_en(dual_en), .cont(ctrl_q.cont),
        .count(count), .sel_b(sel_b), .evt(evt), .stop_req(stop_req)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {{PAD{1'b0}}, ctrl_read(ctrl_q, sel_b)};
            A_CNT:   bus_rdata = count;
            A_CMPA:  bus_rdata = cmp_a;
            default: bus_rdata = cmp_b;
        endcase
    end

    // R4: a request is raised only while interrupts were enabled
    a_r4_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl_q.ie));
    // R7/R8: a one-shot end of pass with no control write clears run
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (evt && !ctrl_q.cont && !dual_en && !wr_ctrl) |=> !ctrl_q.run);
    // R8: the end of the A pass in one-shot dual mode keeps run set
    a_r8_a_pass_keeps_run: assert property (@(posedge clk) disable iff (rst)
        (evt && dual_en && !sel_b && !wr_ctrl) |=> ctrl_q.run);
    // R11: a control write without bit 1 keeps run
    a_r11_run_guard: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !bus_wdata[BIT_WE]) |=> ctrl_q.run == $past(ctrl_q.run));
    // R6: the single-mode low strobe lasts exactly one clock
    a_r6_one_clock_low: assert property (@(posedge clk) disable iff (rst)
        (pulse_lo && !evt) |=> !pulse_lo);
endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        ext_in = 1'b0;
    logic        pre_tick = 1'b0;
    logic        tmr_out, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_cmp_timer dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .pre_tick(pre_tick), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // control word: bit0 run, bit1 run write enable, bit2 continuous,
    // bit3 dual, bits5:4 source, bit6 interrupt enable
    function automatic logic [15:0] cw(input bit run, input bit we, input bit cont,
                                       input bit dual, input logic [1:0] src, input bit ie);
        return {9'd0, ie, src, dual, cont, we, run};
    endfunction

    task automatic halt_clear();
        wr(2'd0, cw(0, 1, 0, 0, 2'd0, 0));
        wr(2'd1, 16'd0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register reset", v, 16'd0);
        end
        check("R1 tmr_out reset", {15'd0, tmr_out}, 16'd1);
        check("R1 irq reset", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_single_wrap();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd5);
        wr(2'd0, cw(1, 1, 1, 0, 2'd0, 1));
        step(4);
        rd(2'd1, v); check("R2 count steps", v, 16'd4);
        check("R4 no irq before event", {15'd0, irq}, 16'd0);
        step(1);
        rd(2'd1, v); check("R3 wrap at compare", v, 16'd0);
        check("R4 irq on event", {15'd0, irq}, 16'd1);
        check("R6 out low after event", {15'd0, tmr_out}, 16'd0);
        step(1);
        rd(2'd1, v); check("R3 count after wrap", v, 16'd1);
        check("R4 irq one clock", {15'd0, irq}, 16'd0);
        check("R6 out high again", {15'd0, tmr_out}, 16'd1);
        wr(2'd0, cw(0, 1, 1, 0, 2'd0, 1));
        rd(2'd1, v);
        step(3);
        begin
            logic [15:0] v2;
            rd(2'd1, v2); check("R2 hold while stopped", v2, v);
        end
    endtask

    task automatic t_dual();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd2);
        wr(2'd0, cw(1, 1, 1, 1, 2'd0, 0));
        step(2);
        check("R5 out high in A", {15'd0, tmr_out}, 16'd1);
        step(1);
        check("R5 out low in B", {15'd0, tmr_out}, 16'd0);
        check("R4 no irq with ie clear", {15'd0, irq}, 16'd0);
        rd(2'd0, v); check("R5 status B active", {15'd0, v[7]}, 16'd1);
        step(2);
        check("R5 out high back in A", {15'd0, tmr_out}, 16'd1);
        rd(2'd0, v); check("R5 status A active", {15'd0, v[7]}, 16'd0);
        wr(2'd0, cw(0, 1, 1, 1, 2'd0, 0));
    endtask

    task automatic t_oneshot_single();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd3);
        wr(2'd0, cw(1, 1, 0, 0, 2'd0, 0));
        step(3);
        rd(2'd0, v); check("R7 run cleared", {15'd0, v[0]}, 16'd0);
        step(3);
        rd(2'd1, v); check("R7 count stays zero", v, 16'd0);
    endtask

    task automatic t_oneshot_dual();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd2);
        wr(2'd0, cw(1, 1, 0, 1, 2'd0, 0));
        step(2);
        rd(2'd0, v); check("R8 run kept after A", {15'd0, v[0]}, 16'd1);
        step(2);
        rd(2'd0, v); check("R8 run cleared after B", {15'd0, v[0]}, 16'd0);
        step(3);
        rd(2'd1, v); check("R8 count stays zero", v, 16'd0);
    endtask

    task automatic t_full_range();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd0);
        wr(2'd0, cw(1, 1, 1, 0, 2'd0, 1));
        wr(2'd1, 16'd65533);
        rd(2'd1, v); check("R12 write beats step", v, 16'd65533);
        step(2);
        rd(2'd1, v); check("R3 reaches 65535", v, 16'd65535);
        check("R4 no early irq", {15'd0, irq}, 16'd0);
        step(1);
        rd(2'd1, v); check("R3 zero compare wraps", v, 16'd0);
        check("R4 irq at full wrap", {15'd0, irq}, 16'd1);
    endtask

    task automatic t_external();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd100);
        wr(2'd0, cw(1, 1, 1, 0, 2'd1, 0));
        step(5);
        rd(2'd1, v); check("R9 no count without edge", v, 16'd0);
        for (int i = 0; i < 2; i++) begin
            ext_in = 1'b1; step(4);
            ext_in = 1'b0; step(4);
        end
        ext_in = 1'b1; step(12);
        rd(2'd1, v); check("R9 one per edge", v, 16'd3);
        ext_in = 1'b0; step(4);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        halt_clear();
        wr(2'd2, 16'd100);
        wr(2'd0, cw(1, 1, 1, 0, 2'd2, 0));
        for (int i = 0; i < 4; i++) begin
            pre_tick = 1'b1; step(1);
            pre_tick = 1'b0; step(2);
        end
        rd(2'd1, v); check("R10 counts prescaler ticks", v, 16'd4);
    endtask

    task automatic t_guard();
        logic [15:0] v;
        halt_clear();
        wr(2'd0, cw(1, 0, 0, 0, 2'd0, 1));
        rd(2'd0, v);
        check("R11 run not set without enable", {15'd0, v[0]}, 16'd0);
        check("R11 other field updated", {15'd0, v[6]}, 16'd1);
        wr(2'd2, 16'd1000);
        wr(2'd0, cw(1, 1, 1, 0, 2'd0, 0));
        wr(2'd0, cw(0, 0, 1, 0, 2'd0, 0));
        rd(2'd0, v);
        check("R11 run kept without enable", {15'd0, v[0]}, 16'd1);
        wr(2'd0, cw(0, 1, 1, 0, 2'd0, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1);
        t_reset();
        t_single_wrap();
        t_dual();
        t_oneshot_single();
        t_oneshot_dual();
        t_full_range();
        t_external();
        t_prescale();
        t_guard();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule